// File: doc/BRIEF.md
# Maskable Clear-on-Read Interrupt Register

This block gathers five single-cycle event strobes into one interrupt register that a CPU sees at one address. Each event sets its own flag bit, whatever the enable mask says. Events whose mask bit is set also raise a summary bit and pull an active-low interrupt line. A read returns the flags and the summary bit in the same cycle. At the following clock edge all of those bits clear and the interrupt line is released.

The enable mask cannot be read, and it is never loaded directly. On a write, the top bit of the byte selects set mode (1) or clear mode (0). Each 1 in the lower bits names a mask bit that the write changes. Mask bits at positions that hold 0 keep their value.

The register port is a plain strobe interface and has no back-pressure. A read or a write is accepted in every cycle that its strobe is high. A read and a write in the same cycle both take effect. The event inputs also have no handshake: an event strobe is counted once in each cycle it is high.

Top module: `irq_aggregator`

## Requirements
- R1: The read value carries the flags at these positions: bit 0 is timer A underflow, bit 1 is timer B underflow, bit 2 is the time-of-day alarm, bit 3 is serial full/empty, and bit 4 is the external flag. Event input `evt_stb[i]` feeds flag bit i. Read bits 5 and 6 are always 0. Bit 7 is the summary bit.
- R2: An event strobe sets its flag bit at the next clock edge whether or not the source is enabled. The flag stays set until a read.
- R3: An event whose mask bit is 1 sets the summary bit and drives `irq_n` low at the next clock edge. Both stay asserted until a read, even if the mask bit is later cleared.
- R4: `rd_data` shows the register contents in the same cycle as `rd_stb`. At the next edge all flag bits and the summary bit clear, and `irq_n` returns high.
- R5: A write with bit 7 = 1 sets every mask bit whose position holds 1 in the written byte.
- R6: A write with bit 7 = 0 clears every mask bit whose position holds 1 in the written byte.
- R7: In either mode, mask bits at positions that hold 0 in the written byte keep their value. Written bits 5 and 6 have no effect.
- R8: An event strobe in the same cycle as a read is not lost. It is latched after the clear and appears on the next read, and it raises the summary bit if it is enabled.
- R9: A write that enables a source whose flag is already latched sets the summary bit and drives `irq_n` low at the next clock edge.
- R10: Reset clears the mask, all flags and the summary bit, and drives `irq_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_stb | input | 5 | Event strobes, one per source, bit i feeds flag i |
| rd_stb | input | 1 | Register read strobe |
| wr_stb | input | 1 | Register write strobe |
| wr_data | input | 8 | Written byte: bit 7 selects set or clear, low bits select mask bits |
| rd_data | output | 8 | Summary bit, two zero bits, five flag bits |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions check on every cycle the rules that hold cycle by cycle:
- every strobed event shows up in the flags one cycle later;
- an enabled event pulls `irq_n` low;
- the interrupt stays low until a read;
- a quiet read leaves nothing behind;
- the set/clear mask update touches only the selected bits.

Some behaviours can only be shown by the bench's ordered scenarios:
- the exact byte returned by each read;
- that a masked-off event sets a flag but raises no interrupt;
- that an event arriving during a read survives to the next read;
- that enabling an already-latched source raises the interrupt;
- that clearing the mask afterwards does not withdraw it.

// File: rtl/irq_aggregator_pkg.sv
package irq_aggregator_pkg;
  localparam int unsigned SRC_COUNT = 5;
  localparam int unsigned BYTE_W    = 8;

  // Flag positions in the read byte
  localparam int unsigned POS_TMR_A  = 0;
  localparam int unsigned POS_TMR_B  = 1;
  localparam int unsigned POS_ALARM  = 2;
  localparam int unsigned POS_SERIAL = 3;
  localparam int unsigned POS_FLAG   = 4;

  typedef enum logic {
    MASK_CLEAR = 1'b0,
    MASK_SET   = 1'b1
  } mask_op_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_stb,
  input  logic            rd_stb,
  output logic [NSRC-1:0] flags_q,
  output logic [NSRC-1:0] flags_nxt
);
  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    // A read clears first, so an event in the same cycle is still latched
    assign flags_nxt[i] = (flags_q[i] & ~rd_stb) | evt_stb[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[i] <= 1'b0;
      else        flags_q[i] <= flags_nxt[i];
    end
  end
endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit
  import irq_aggregator_pkg::*;
#(
  parameter int unsigned NSRC   = 5,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NSRC-1:0]   mask_q,
  output logic [NSRC-1:0]   mask_nxt
);
  logic [NSRC-1:0] sel;
  mask_op_e        op;

  assign sel = wr_data[NSRC-1:0];
  assign op  = mask_op_e'(wr_data[DATA_W-1]);

  always_comb begin
    mask_nxt = mask_q;
    if (wr_stb) begin
      if (op == MASK_SET) mask_nxt = mask_q | sel;
      else                mask_nxt = mask_q & ~sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_nxt;
  end
endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
  parameter int unsigned NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_stb,
  input  logic [NSRC-1:0] flags_nxt,
  input  logic [NSRC-1:0] mask_nxt,
  output logic            sum_q
);
  logic sum_nxt;

  // Sticky until read; raised by any enabled flag after this cycle's updates
  assign sum_nxt = (sum_q & ~rd_stb) | (|(flags_nxt & mask_nxt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= 1'b0;
    else        sum_q <= sum_nxt;
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int unsigned NSRC   = irq_aggregator_pkg::SRC_COUNT,
  parameter int unsigned DATA_W = irq_aggregator_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt_stb,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_n
);
  localparam int unsigned PAD_W = DATA_W - 1 - NSRC;

  logic [NSRC-1:0] flags_q, flags_nxt;
  logic [NSRC-1:0] mask_q, mask_nxt;
  logic            sum_q;

  irq_flag_bank #(.NSRC(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt_stb(evt_stb), .rd_stb(rd_stb),
    .flags_q(flags_q), .flags_nxt(flags_nxt)
  );

  irq_mask_unit #(.NSRC(NSRC), .DATA_W(DATA_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .mask_q(mask_q), .mask_nxt(mask_nxt)
  );

  irq_summary #(.NSRC(NSRC)) u_sum (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb),
    .flags_nxt(flags_nxt), .mask_nxt(mask_nxt), .sum_q(sum_q)
  );

  if (PAD_W > 0) begin : g_pad
    assign rd_data = {sum_q, {PAD_W{1'b0}}, flags_q};
  end else begin : g_nopad
    assign rd_data = {sum_q, flags_q};
  end

  assign irq_n = ~sum_q;
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int unsigned NSRC   = 5,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   evt_stb,
  input logic              rd_stb,
  input logic              wr_stb,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq_n,
  input logic [NSRC-1:0]   mask_q
);
  AST_EVT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rd_data[NSRC-1:0] & $past(evt_stb)) == $past(evt_stb))); // R2

  AST_ENABLED_EVT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_stb & mask_q) != '0) |=> !irq_n); // R3

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !rd_stb) |=> !irq_n); // R3

  AST_QUIET_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && evt_stb == '0) |=> (rd_data == '0 && irq_n)); // R4

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_data[DATA_W-1]) |=>
      ((mask_q & $past(wr_data[NSRC-1:0])) == $past(wr_data[NSRC-1:0]))); // R5

  AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !wr_data[DATA_W-1]) |=> ((mask_q & $past(wr_data[NSRC-1:0])) == '0)); // R6

  AST_MASK_UNSELECTED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((mask_q ^ $past(mask_q)) &
      ~($past(wr_data[NSRC-1:0]) & {NSRC{$past(wr_stb)}})) == '0)); // R7
endmodule

bind irq_aggregator irq_aggregator_chk #(.NSRC(NSRC), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_stb(evt_stb), .rd_stb(rd_stb),
  .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n),
  .mask_q(mask_q)
);

// File: tb/irq_aggregator_tb_top.sv
`timescale 1ns/1ps
module irq_aggregator_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] evt_stb = '0;
  logic       rd_stb = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq_n;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_aggregator dut_i (
    .clk(clk), .rst_n(rst_n), .evt_stb(evt_stb), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n)
  );

  // Vector fields: {evt[23:19], wr[18], wdat[17:10], rd[9], exp_data[8:1], exp_irq_n[0]}
  // The expected values are those seen before this step's inputs take effect
  localparam int NV = 21;
  localparam logic [23:0] VEC [NV] = '{
    {5'h00, 1'b0, 8'h00, 1'b1, 8'h00, 1'b1}, // 0  R10 reset state read
    {5'h01, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1}, // 1  R2 timer A event, masked off
    {5'h00, 1'b0, 8'h00, 1'b1, 8'h01, 1'b1}, // 2  R1 R2 bit0 latched, no irq
    {5'h00, 1'b1, 8'h81, 1'b0, 8'h00, 1'b1}, // 3  R5 set mask bit0
    {5'h02, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1}, // 4  R2 timer B, not enabled
    {5'h01, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1}, // 5  R3 enabled timer A
    {5'h00, 1'b0, 8'h00, 1'b1, 8'h83, 1'b0}, // 6  R3 R1 summary + bits 0,1
    {5'h00, 1'b0, 8'h00, 1'b1, 8'h00, 1'b1}, // 7  R4 cleared, irq released
    {5'h00, 1'b1, 8'hFE, 1'b0, 8'h00, 1'b1}, // 8  R5 R7 set 1..4, bits 5,6 ignored
    {5'h00, 1'b1, 8'h06, 1'b0, 8'h00, 1'b1}, // 9  R6 clear bits 1,2
    {5'h04, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1}, // 10 R6 alarm now masked off
    {5'h10, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1}, // 11 R7 flag bit4 still enabled
    {5'h00, 1'b0, 8'h00, 1'b1, 8'h94, 1'b0}, // 12 R7 read bits 2,4 + summary
    {5'h08, 1'b0, 8'h00, 1'b1, 8'h00, 1'b1}, // 13 R8 serial event during read
    {5'h00, 1'b0, 8'h00, 1'b1, 8'h88, 1'b0}, // 14 R8 event kept for next read
    {5'h00, 1'b1, 8'h7F, 1'b0, 8'h00, 1'b1}, // 15 R6 clear whole mask
    {5'h1F, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1}, // 16 R2 all sources, none enabled
    {5'h00, 1'b1, 8'h90, 1'b0, 8'h00, 1'b1}, // 17 R9 enable latched bit4
    {5'h00, 1'b1, 8'h10, 1'b0, 8'h00, 1'b0}, // 18 R9 irq low; clear mask bit4
    {5'h00, 1'b0, 8'h00, 1'b1, 8'h9F, 1'b0}, // 19 R3 summary held after mask clear
    {5'h00, 1'b0, 8'h00, 1'b1, 8'h00, 1'b1}  // 20 R4 empty after read
  };

  function automatic string req_of(int i);
    case (i)
      0: return "R10";
      1, 4, 16: return "R2";
      2: return "R1";
      3, 8: return "R5";
      5, 6, 19: return "R3";
      7, 20: return "R4";
      9, 10, 15: return "R6";
      11, 12: return "R7";
      13, 14: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s rd_data actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic check1(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s irq_n actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step(logic [4:0] e, logic w, logic [7:0] wd, logic r);
    @(negedge clk);
    evt_stb = e; wr_stb = w; wr_data = wd; rd_stb = r;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][23:19], VEC[i][18], VEC[i][17:10], VEC[i][9]);
      #1;
      if (VEC[i][9]) check8(req_of(i), rd_data, VEC[i][8:1]);
      check1(req_of(i), irq_n, VEC[i][0]);
    end
    step('0, 1'b0, '0, 1'b0);

    // R10: reset in the middle of activity clears mask, flags and summary
    step(5'h00, 1'b1, 8'h9F, 1'b0);
    step(5'h1F, 1'b0, 8'h00, 1'b0);
    step(5'h00, 1'b0, 8'h00, 1'b0);
    #1 check1("R3", irq_n, 1'b0);
    rst_n = 1'b0;
    #1 check8("R10", rd_data, 8'h00);
    check1("R10", irq_n, 1'b1);
    @(negedge clk) rst_n = 1'b1;
    step(5'h01, 1'b0, 8'h00, 1'b0);   // R10: mask was cleared, so no irq
    step(5'h00, 1'b0, 8'h00, 1'b1);
    #1 check8("R10", rd_data, 8'h01);
    check1("R10", irq_n, 1'b1);

    // R8 + R4: an enabled event and a read in the same cycle
    step(5'h00, 1'b1, 8'h84, 1'b0);   // enable alarm (bit2)
    step(5'h04, 1'b0, 8'h00, 1'b0);
    step(5'h04, 1'b0, 8'h00, 1'b1);   // read while alarm strobes again
    #1 check8("R8", rd_data, 8'h84);
    step(5'h00, 1'b0, 8'h00, 1'b1);
    #1 check8("R8", rd_data, 8'h84);
    check1("R8", irq_n, 1'b0);
    step(5'h00, 1'b0, 8'h00, 1'b0);
    #1 check1("R4", irq_n, 1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule